// File: doc/BRIEF.md
# Conflict-Fill Instruction Cache

This block sits between a program sequencer and a program-memory bus that carries both instructions and data. Most fetches go straight to the bus and are not kept. When a fetch lands in the same cycle as a data transfer on that bus, the block stalls the sequencer for one cycle. In the following cycle it takes the instruction from the bus and stores it. The next time that address is fetched, usually on a later pass of a loop, the instruction comes from the cache and the bus stays free for data.

Storage is two ways of sixteen sets, so it holds 32 instructions of 48 bits. A set is selected by the low address bits and checked against a tag made of the remaining address bits. A flush input empties the cache. A freeze input keeps the current contents in place while hits continue.

Top module: `conflict_icache`

## Requirements
- R1: The cache has 2 ways × 16 sets. The set index is fetch_addr[3:0] and the tag is fetch_addr[23:4]. A fetch whose tag matches a valid entry in its set raises hit in the same cycle, returns the stored 48-bit word on instr and holds stall low.
- R2: A miss while conflict is low returns bus_data on instr in the same cycle, with hit and stall low. Nothing is stored, so a repeat of the same address misses again.
- R3: A hit is served from the cache with stall low even when conflict is high.
- R4: A miss while conflict is high raises stall for exactly one cycle. The next cycle is a fill cycle: stall and hit are low, instr equals bus_data, and that word is stored under the address latched in the stall cycle. fetch_addr and conflict are ignored during the fill cycle.
- R5: On a fill, an empty way is chosen first, way 0 before way 1. If both ways are valid, the least-recently-used way is replaced. A hit or a fill marks the other way of that set as least recently used.
- R6: Flush high at a clock edge clears every valid bit. A fill in the same cycle stores nothing. A lookup in the flush cycle still sees the contents from before the flush.
- R7: While freeze is high, a conflict miss still stalls and fills, but nothing is stored. Hits and recency updates continue.
- R8: After reset all entries are invalid, no fill is pending, and hit and stall are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all entries |
| freeze | input | 1 | Block new entries; hits continue |
| fetch_addr | input | 24 | Instruction fetch address |
| conflict | input | 1 | Data access on the program bus this cycle |
| bus_data | input | 48 | Instruction word read from the program bus |
| instr | output | 48 | Instruction to the sequencer (valid when stall is low) |
| hit | output | 1 | Instruction came from the cache |
| stall | output | 1 | Sequencer must hold this cycle |

## Verification
The bench uses the default parameters: 24-bit addresses, 16 sets and 48-bit words. With these values a sweep over every set index is short, and the bench runs several tags into single sets to exercise eviction. A scoreboard model of the valid, tag and recency state predicts hit, stall and instr for every fetch. The bench drives a different address and a high conflict during each fill cycle, so that a fill stored under the wrong address is caught later. Flush and freeze are both applied during lookup cycles and during fill cycles.

// File: rtl/icache_pkg.sv
package icache_pkg;
    typedef enum logic {
        PH_LOOK = 1'b0,
        PH_FILL = 1'b1
    } phase_e;
endpackage

// File: rtl/icache_way_store.sv
module icache_way_store #(
    parameter int SETS   = 16,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 48,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data
);
    logic [SETS-1:0]   valid_d, valid_q;
    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [DATA_W-1:0] data_mem [SETS];

    always_comb begin
        valid_d = valid_q;
        if (flush) begin
            valid_d = '0;
        end else if (wr_en) begin
            valid_d[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            data_mem[wr_idx] <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_mem[rd_idx];
    assign rd_data  = data_mem[rd_idx];

    // R6: a flush leaves no valid entry behind
    p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));
endmodule

// File: rtl/icache_lru.sv
module icache_lru #(
    parameter int SETS = 16,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_way,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_old_way
);
    logic [SETS-1:0] old_d, old_q;

    always_comb begin
        old_d = old_q;
        if (upd_en) old_d[upd_idx] = ~upd_way;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) old_q <= '0;
        else        old_q <= old_d;
    end

    assign rd_old_way = old_q[rd_idx];

    // R5: the way just used is never the next victim
    p_recency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (old_q[$past(upd_idx)] != $past(upd_way)));
endmodule

// File: rtl/conflict_icache.sv
module conflict_icache #(
    parameter int ADDR_W = 24,
    parameter int SETS   = 16,
    parameter int DATA_W = 48,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W,
    localparam int WAYS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              freeze,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              conflict,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] instr,
    output logic              hit,
    output logic              stall
);
    import icache_pkg::*;

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [ADDR_W-1:0] look_addr;
    logic [IDX_W-1:0]  look_idx;
    logic [TAG_W-1:0]  look_tag;
    logic [WAYS-1:0]   way_valid, way_hit, way_wr;
    logic [TAG_W-1:0]  way_tag  [WAYS];
    logic [DATA_W-1:0] way_data [WAYS];
    logic              old_way, victim, alloc_en, lru_upd, lru_way, hit_way;

    assign look_addr = (ctl_q.phase == PH_FILL) ? ctl_q.addr : fetch_addr;
    assign look_idx  = look_addr[IDX_W-1:0];
    assign look_tag  = look_addr[ADDR_W-1:IDX_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        icache_way_store #(
            .SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)
        ) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .wr_en    (way_wr[w]),
            .wr_idx   (look_idx),
            .wr_tag   (look_tag),
            .wr_data  (bus_data),
            .rd_idx   (look_idx),
            .rd_valid (way_valid[w]),
            .rd_tag   (way_tag[w]),
            .rd_data  (way_data[w])
        );
        assign way_hit[w] = way_valid[w] && (way_tag[w] == look_tag);
        assign way_wr[w]  = alloc_en && (victim == w[0]);
    end

    icache_lru #(.SETS(SETS)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_en     (lru_upd),
        .upd_idx    (look_idx),
        .upd_way    (lru_way),
        .rd_idx     (look_idx),
        .rd_old_way (old_way)
    );

    assign hit_way = way_hit[1];
    assign victim  = !way_valid[0] ? 1'b0 : (!way_valid[1] ? 1'b1 : old_way);

    always_comb begin
        ctl_d    = ctl_q;
        hit      = 1'b0;
        stall    = 1'b0;
        instr    = bus_data;
        alloc_en = 1'b0;
        lru_upd  = 1'b0;
        lru_way  = hit_way;
        if (ctl_q.phase == PH_FILL) begin
            alloc_en    = !freeze && !flush;
            lru_upd     = alloc_en;
            lru_way     = victim;
            ctl_d.phase = PH_LOOK;
        end else if (|way_hit) begin
            hit     = 1'b1;
            instr   = way_data[hit_way];
            lru_upd = 1'b1;
        end else if (conflict) begin
            stall       = 1'b1;
            ctl_d.phase = PH_FILL;
            ctl_d.addr  = fetch_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{phase: PH_LOOK, addr: '0};
        else        ctl_q <= ctl_d;
    end

    p_hit_no_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !stall);
    p_stall_needs_conflict_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> conflict);
    p_stall_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!stall && !hit));
    p_one_victim_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_wr));
    p_freeze_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> (way_wr == '0));
endmodule

// File: tb/conflict_icache_tb.sv
module conflict_icache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0, freeze = 1'b0, conflict = 1'b0;
    logic [23:0] fetch_addr = '0;
    logic [47:0] bus_data = '0;
    logic [47:0] instr;
    logic        hit, stall;

    int n_tests = 0, n_fail = 0;
    logic fl_fill = 1'b0;
    logic finished = 1'b0;

    // scoreboard state
    logic        mv [2][16];
    logic [19:0] mt [2][16];
    logic [47:0] md [2][16];
    logic        mold [16];

    always #4 clk = ~clk;

    conflict_icache u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .freeze(freeze),
        .fetch_addr(fetch_addr), .conflict(conflict), .bus_data(bus_data),
        .instr(instr), .hit(hit), .stall(stall)
    );

    function automatic logic [47:0] pat(input logic [23:0] a);
        return {a ^ 24'hC3A5F0, ~a};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [23:0] a, input logic c, input string req);
        logic [3:0]  ix = a[3:0];
        logic [19:0] tg = a[23:4];
        logic mh = 1'b0;
        logic mw = 1'b0;
        logic vic;
        for (int w = 0; w < 2; w++)
            if (mv[w][ix] && mt[w][ix] == tg) begin mh = 1'b1; mw = w[0]; end
        @(negedge clk);
        fetch_addr = a; conflict = c;
        bus_data = mh ? 48'hBAD0_0BAD_F00D : pat(a);
        #2;
        chk(req, "hit", {47'd0, hit}, {47'd0, mh});
        if (mh) begin
            chk(req, "stall on hit", {47'd0, stall}, 48'd0);
            chk(req, "cached instr", instr, md[mw][ix]);
            mold[ix] = ~mw;
        end else if (c) begin
            chk(req, "stall on conflict miss", {47'd0, stall}, 48'd1);
            @(negedge clk);
            fetch_addr = ~a; conflict = 1'b1; bus_data = pat(a); flush = fl_fill;
            #2;
            chk(req, "fill stall", {47'd0, stall}, 48'd0);
            chk(req, "fill hit", {47'd0, hit}, 48'd0);
            chk(req, "fill instr", instr, pat(a));
            vic = !mv[0][ix] ? 1'b0 : (!mv[1][ix] ? 1'b1 : mold[ix]);
            if (!freeze && !fl_fill) begin
                mv[vic][ix] = 1'b1; mt[vic][ix] = tg; md[vic][ix] = pat(a);
                mold[ix] = ~vic;
            end
            if (fl_fill)
                for (int s = 0; s < 16; s++) begin mv[0][s] = 1'b0; mv[1][s] = 1'b0; end
            @(posedge clk); #1;
            flush = 1'b0; conflict = 1'b0;
        end else begin
            chk(req, "stall on plain miss", {47'd0, stall}, 48'd0);
            chk(req, "bus instr", instr, pat(a));
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 16; s++) begin
            mv[0][s] = 1'b0; mv[1][s] = 1'b0; mold[s] = 1'b0;
        end
        #20 rst_n = 1'b1;
        @(negedge clk); #2;
        chk("R8", "reset hit", {47'd0, hit}, 48'd0);
        chk("R8", "reset stall", {47'd0, stall}, 48'd0);

        // R2: plain misses never allocate
        for (int s = 0; s < 16; s++) step({20'h00010, s[3:0]}, 1'b0, "R2");
        for (int s = 0; s < 16; s++) step({20'h00010, s[3:0]}, 1'b0, "R2 repeat");

        // R4 fill, then R1 hit on every set
        for (int s = 0; s < 16; s++) step({20'h0A001, s[3:0]}, 1'b1, "R4");
        for (int s = 0; s < 16; s++) step({20'h0A001, s[3:0]}, 1'b0, "R1");
        // R3: hit during a conflict
        for (int s = 0; s < 16; s++) step({20'h0A001, s[3:0]}, 1'b1, "R3");

        // R5: second way, recency, eviction
        step({20'h0B002, 4'h3}, 1'b1, "R5");
        step({20'h0B002, 4'h3}, 1'b0, "R5");
        step({20'h0A001, 4'h3}, 1'b0, "R5");
        step({20'h0C003, 4'h3}, 1'b1, "R5");
        step({20'h0A001, 4'h3}, 1'b0, "R5");
        step({20'h0B002, 4'h3}, 1'b0, "R5");
        step({20'h0C003, 4'h3}, 1'b0, "R5");

        // R7: freeze keeps contents, hits continue
        freeze = 1'b1;
        step({20'h0D004, 4'h5}, 1'b1, "R7");
        step({20'h0D004, 4'h5}, 1'b0, "R7");
        step({20'h0A001, 4'h5}, 1'b0, "R7");
        freeze = 1'b0;

        // R6: flush during a fill drops the fill
        fl_fill = 1'b1;
        step({20'h0E005, 4'h7}, 1'b1, "R6");
        fl_fill = 1'b0;
        step({20'h0E005, 4'h7}, 1'b0, "R6");
        for (int s = 0; s < 16; s++) step({20'h0A001, s[3:0]}, 1'b1, "R6 refill");

        // R6: flush in a lookup cycle still hits, then everything misses
        @(negedge clk);
        fetch_addr = {20'h0A001, 4'h0}; conflict = 1'b0; flush = 1'b1;
        #2;
        chk("R6", "hit in flush cycle", {47'd0, hit}, 48'd1);
        @(posedge clk); #1 flush = 1'b0;
        for (int s = 0; s < 16; s++) begin mv[0][s] = 1'b0; mv[1][s] = 1'b0; end
        for (int s = 0; s < 16; s++) step({20'h0A001, s[3:0]}, 1'b0, "R6 after flush");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule